// File: doc/BRIEF.md
# Protection Event Delay Qualifier

This block turns level-type protection detections into one-cycle timeout strobes. It has six channels: overcharge, overdischarge, overcurrent-1, overcurrent-2, load short and abnormal charge current. A strobe fires only after a request has stayed high, without a break, for that channel's delay. Delays are counted in ticks of a slow time base of roughly 3.5 kHz. The load-short channel counts a separate, faster tick, because its delay is shorter than one slow period.

The overcurrent-2 and load-short channels start timing when overcurrent-1 is first detected. Each of them fires once its own detection is present and its delay, measured from that start, has passed. Whichever fires first tells the surrounding controller to shut off discharge.

A two-bit test-mode input selects the delay set:
- normal delays;
- reduced delays, where every slow-tick delay is divided by a power of two and the short delay is left alone;
- bypass, where detections pass through at once.

Every delay is a parameter, so one build can carry either variant's profile.

Top module: `prot_delay_timer`

## Requirements
- R1: While and after reset, with no request, all six bits of `trip` are 0.
- R2: Bit index of `det_req` and `trip`: 0 overcharge, 1 overdischarge, 2 overcurrent-1, 3 overcurrent-2, 4 load short, 5 abnormal charge. In normal mode a channel's `trip` bit goes high for one cycle on the clock edge after the edge that samples the Nth tick during a continuous request. N is that channel's delay parameter.
- R3: If a request goes low for one or more cycles, that channel's count returns to zero, and a later request needs the full delay again.
- R4: A channel strobes at most once per continuous request. After its strobe it stays low until the request drops.
- R5: Channels 3 and 4 count while `det_req[2]` is high, and are cleared when it is low. Each fires once its own request is high and its count has reached its delay. The firing can be late if the own request rises after the delay has elapsed, and then comes on the following edge. Without `det_req[2]` neither channel ever fires.
- R6: Channel 4 counts `fast_tick`. All other channels count `slow_tick`.
- R7: Channel 5 uses the overcharge delay parameter.
- R8: With `test_mode` = 2'b01, each slow-tick delay becomes max(1, delay >> RED_SHIFT). Channel 4 keeps its normal delay.
- R9: With `test_mode` = 2'b10, a qualifying request strobes on the first edge that samples it, with no tick needed.
- R10: With `test_mode` = 2'b11, delays are the same as with 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle pulse of the ~3.5 kHz time base |
| fast_tick | input | 1 | One-cycle pulse of the faster time base used by channel 4 |
| test_mode | input | 2 | 00/11 normal, 01 reduced, 10 bypass |
| det_req | input | 6 | Level detection requests, one per channel |
| trip | output | 6 | One-cycle timeout strobes, one per channel |

## Verification
The bench builds the block with short delays: 130, 20, 5 and 3 slow ticks for channels 0 to 3, and 2 fast ticks for the short channel. RED_SHIFT stays at 6. With these values the reduced mode gives a delay of 2 for the longest channel, and the minimum-of-one rule applies to the others.

The bench sweeps every channel in all four test modes, and checks each bit every cycle against an expected firing edge. That edge is computed from tick counts, and the same checks confirm no further strobe follows. Further runs cover a request broken before its delay, and overcurrent-2 or short requests that arrive after overcurrent-1 has already timed out or arrive without overcurrent-1.

// File: rtl/prot_delay_pkg.sv
package prot_delay_pkg;

    localparam int NCH = 6;

    localparam int CH_OVCH  = 0;
    localparam int CH_OVDIS = 1;
    localparam int CH_OC1   = 2;
    localparam int CH_OC2   = 3;
    localparam int CH_SHORT = 4;
    localparam int CH_ABCH  = 5;

    typedef enum logic [1:0] {
        MODE_NORMAL     = 2'b00,
        MODE_REDUCED    = 2'b01,
        MODE_BYPASS     = 2'b10,
        MODE_NORMAL_ALT = 2'b11
    } tmode_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int shrink(input int base, input int sh);
        return ((base >> sh) == 0) ? 1 : (base >> sh);
    endfunction

endpackage

// File: rtl/dly_limit_sel.sv
module dly_limit_sel
    import prot_delay_pkg::*;
#(
    parameter int CW      = 13,
    parameter int BASE    = 4550,
    parameter int SHIFT   = 6,
    parameter bit SHRINKS = 1'b1
) (
    input  logic [1:0]    mode,
    output logic [CW-1:0] limit
);

    localparam int REDUCED = SHRINKS ? shrink(BASE, SHIFT) : BASE;

    always_comb begin
        unique case (tmode_e'(mode))
            MODE_REDUCED: limit = CW'(REDUCED);
            MODE_BYPASS:  limit = '0;
            default:      limit = CW'(BASE);
        endcase
    end

    // R8: a reduced limit never exceeds the normal one and is never zero
    always_comb begin
        if (tmode_e'(mode) == MODE_REDUCED)
            assert_reduced_range_R8: assert (limit <= CW'(BASE) && limit != '0);
    end

endmodule

// File: rtl/dly_channel.sv
module dly_channel #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          hold,
    input  logic          fire_req,
    input  logic [CW-1:0] limit,
    output logic          timeout
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
        logic          strobe;
    } ch_state_t;

    ch_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        if (!hold) begin
            s_d.cnt  = '0;
            s_d.done = 1'b0;
        end else begin
            if (tick && (s_q.cnt < limit))
                s_d.cnt = s_q.cnt + 1'b1;
            if ((s_q.cnt >= limit) && fire_req && !s_q.done) begin
                s_d.strobe = 1'b1;
                s_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign timeout = s_q.strobe;

    assert_clear_on_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> (s_q.cnt == '0) && !timeout);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    assert_no_early_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> ($past(s_q.cnt) >= $past(limit)) && $past(fire_req) && $past(hold));

    assert_done_after_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && hold) |=> s_q.done);

endmodule

// File: rtl/prot_delay_timer.sv
module prot_delay_timer
    import prot_delay_pkg::*;
#(
    parameter int OVCH_TICKS   = 4550,
    parameter int OVDIS_TICKS  = 613,
    parameter int OC1_TICKS    = 42,
    parameter int OC2_TICKS    = 11,
    parameter int SHORT_FTICKS = 9,
    parameter int RED_SHIFT    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slow_tick,
    input  logic       fast_tick,
    input  logic [1:0] test_mode,
    input  logic [5:0] det_req,
    output logic [5:0] trip
);

    localparam int MAXT = imax(imax(OVCH_TICKS, OVDIS_TICKS),
                               imax(imax(OC1_TICKS, OC2_TICKS), SHORT_FTICKS));
    localparam int CW   = $clog2(MAXT + 1);

    function automatic int base_of(input int ch);
        case (ch)
            CH_OVCH:  return OVCH_TICKS;
            CH_OVDIS: return OVDIS_TICKS;
            CH_OC1:   return OC1_TICKS;
            CH_OC2:   return OC2_TICKS;
            CH_SHORT: return SHORT_FTICKS;
            default:  return OVCH_TICKS;
        endcase
    endfunction

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        localparam bit ARMED_BY_OC1 = (ch == CH_OC2) || (ch == CH_SHORT);
        logic [CW-1:0] limit;
        logic          hold;
        logic          tick;

        dly_limit_sel #(
            .CW     (CW),
            .BASE   (base_of(ch)),
            .SHIFT  (RED_SHIFT),
            .SHRINKS(ch != CH_SHORT)
        ) u_lim (
            .mode (test_mode),
            .limit(limit)
        );

        if (ARMED_BY_OC1) begin : g_armed
            assign hold = det_req[CH_OC1];
        end else begin : g_own
            assign hold = det_req[ch];
        end

        if (ch == CH_SHORT) begin : g_fast
            assign tick = fast_tick;
        end else begin : g_slow
            assign tick = slow_tick;
        end

        dly_channel #(.CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .hold    (hold),
            .fire_req(det_req[ch]),
            .limit   (limit),
            .timeout (trip[ch])
        );
    end

    assert_armed_by_oc1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (trip[CH_OC2] || trip[CH_SHORT]) |-> $past(det_req[CH_OC1]));

    assert_bypass_immediate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode == MODE_BYPASS && $past(test_mode) == MODE_BYPASS
         && $rose(det_req[CH_OVDIS])) |=> trip[CH_OVDIS]);

endmodule

// File: tb/tb_prot_delay_timer.sv
module tb_prot_delay_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slow_tick = 1'b0;
    logic       fast_tick = 1'b0;
    logic [1:0] test_mode = 2'b00;
    logic [5:0] det_req = '0;
    logic [5:0] trip;

    int checks = 0;
    int fails  = 0;
    int gc     = 0;

    always #2.5 clk = ~clk;

    prot_delay_timer #(
        .OVCH_TICKS  (130),
        .OVDIS_TICKS (20),
        .OC1_TICKS   (5),
        .OC2_TICKS   (3),
        .SHORT_FTICKS(2),
        .RED_SHIFT   (6)
    ) dut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .test_mode(test_mode), .det_req(det_req), .trip(trip)
    );

    function automatic int base_of(input int ch);
        case (ch)
            0: return 130;
            1: return 20;
            2: return 5;
            3: return 3;
            4: return 2;
            default: return 130;   // R7: abnormal charge shares overcharge delay
        endcase
    endfunction

    function automatic int exp_len(input int ch, input int mode);
        int b = base_of(ch);
        if (mode == 2) return 0;
        if (mode == 1 && ch != 4) return ((b >> 6) == 0) ? 1 : (b >> 6);
        return b;
    endfunction

    task automatic chk(input logic [5:0] act, input logic [5:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic drive_ticks();
        slow_tick = (gc % 4 == 3);
        fast_tick = (gc % 2 == 1);
        gc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            drive_ticks();
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic run_chan(input int ch, input int mode, input int gap, input string tag);
        int L = exp_len(ch, mode);
        int hit = (L == 0) ? 0 : -1;
        int ticks = 0;
        logic [5:0] mask = 6'(1 << ch) | ((ch == 3 || ch == 4) ? 6'b000100 : 6'b0);
        logic is_tick;
        det_req = '0;
        test_mode = 2'(mode);
        idle(gap);
        for (int e = 1; e <= L * 4 + 16; e++) begin
            det_req = mask;
            drive_ticks();
            is_tick = (ch == 4) ? fast_tick : slow_tick;
            @(posedge clk);
            if (is_tick) ticks++;
            if (hit < 0 && ticks == L) hit = e;
            @(negedge clk);
            chk({5'b0, trip[ch]}, {5'b0, (hit >= 0 && e == hit + 1)},
                (hit >= 0 && e > hit + 1) ? "R4 no retrigger" : tag);
        end
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        chk(trip, 6'b0, "R1 in reset");
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk(trip, 6'b0, "R1 after reset");

        for (int mode = 0; mode < 4; mode++) begin
            for (int ch = 0; ch < 6; ch++) begin
                string tag;
                if (mode == 1)      tag = "R8 reduced";
                else if (mode == 2) tag = "R9 bypass";
                else if (mode == 3) tag = "R10 mode 11";
                else if (ch == 5)   tag = "R7 abnormal charge";
                else if (ch == 4)   tag = "R6 fast tick";
                else if (ch == 3)   tag = "R5 oc2 armed";
                else                tag = "R2 normal delay";
                run_chan(ch, mode, 2, tag);
            end
        end

        // R3: broken request restarts the full count
        test_mode = 2'b00;
        det_req = '0;
        idle(2);
        for (int i = 0; i < 12; i++) begin
            det_req = 6'b000100;
            drive_ticks();
            @(posedge clk);
            @(negedge clk);
            chk({5'b0, trip[2]}, 6'b0, "R3 partial count");
        end
        run_chan(2, 0, 1, "R3 restart after drop");

        // R5: own request absent while oc1 counts
        det_req = '0;
        idle(2);
        for (int i = 0; i < 30; i++) begin
            det_req = 6'b000100;
            drive_ticks();
            @(posedge clk);
            @(negedge clk);
            chk({4'b0, trip[4:3]}, 6'b0, "R5 oc1 only");
        end
        // R5: late own requests fire on the next edge
        det_req = 6'b011100;
        drive_ticks();
        @(posedge clk);
        @(negedge clk);
        chk({4'b0, trip[4:3]}, 6'b000011, "R5 late fire");
        drive_ticks();
        @(posedge clk);
        @(negedge clk);
        chk({4'b0, trip[4:3]}, 6'b0, "R5 late single");

        // R5: without overcurrent-1 nothing fires
        det_req = '0;
        idle(2);
        for (int i = 0; i < 30; i++) begin
            det_req = 6'b011000;
            drive_ticks();
            @(posedge clk);
            @(negedge clk);
            chk({4'b0, trip[4:3]}, 6'b0, "R5 unarmed");
        end

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule